// File: doc/BRIEF.md
# MDIO Management Master

This block lets a host processor talk to external Ethernet PHYs over the two-wire management bus. The host sees two 32-bit words. One is a combined command and status word. The other holds the value to be written. Storing a command word with the read or the write flag set sends one complete Clause 22 frame, MSB first, on the MDC clock and MDIO data lines: a preamble of ones, start, opcode, PHY address, register address, turnaround and sixteen data bits.

The flag that started the frame stays set until the frame has finished, and then hardware clears it. Software therefore starts an access and polls the same word until the flag drops. After a read, the sixteen bits returned by the PHY are found in the low half of that word.

MDC is made from the system clock by a divider with a parameter. It is held low whenever no frame runs. The master changes its MDIO output just after the falling edge of MDC and samples the PHY just before the rising edge. During a read it stops driving the line from the turnaround onward.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset both words read as zero, MDC is low and the MDIO output enable is low.
- R2: A command write with bit 27 set and bit 26 clear sends 32 ones, then 01, opcode 01, the PHY address from bits 20:16, the register address from bits 25:21, turnaround 10 and the 16 bits held in the write-data word. That is 64 MDC rising edges in total, MSB first, with the output enable high for the whole frame.
- R3: A command write with bit 26 set and bit 27 clear sends the same header with opcode 10. The output enable drops from the first turnaround bit (bit 46 of the frame) onward. MDIO is sampled at the rising edges of bits 48 to 63, and those 16 values, MSB first, appear in bits 15:0 of the command word once the frame ends.
- R4: The command bit that started a frame reads as set while the frame runs. It reads as clear once the frame has ended.
- R5: A command-word write that arrives while bit 26 or bit 27 is set changes nothing: the address fields keep their values and no further frame follows.
- R6: A command-word write with both bit 26 and bit 27 set is ignored: no frame starts and the command word is unchanged.
- R7: Bits 31:28 of the command word always read as zero. Bits 25:16 read back the addresses last accepted. A command write with neither command bit set updates only those address fields; bits 15:0 keep the last read result.
- R8: MDC is low whenever no command bit is set. While a frame runs, MDC has a period of 2*DIV_HALF system clocks, and MDIO never changes on an MDC rising edge.
- R9: The write-data word is at byte address 4 and keeps only bits 15:0. Bits 31:16 read as zero. The command word is at byte address 0. Any other address has no effect on writes and reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Host write strobe, one cycle per word |
| bus_rd | input | 1 | Host read strobe; data is valid the following cycle |
| bus_addr | input | AW | Host byte address |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Host read data, registered |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable (high = master drives) |
| mdio_i | input | 1 | MDIO value seen on the pin |

## Verification
A wrong bit counter or shift register shows up within one frame. The bench sees a rising-edge count other than 64, a misplaced header bit, or an output enable that is released one bit early or late. A fault in the divider shows up in the spacing of the first two MDC rising edges. A fault in the command bookkeeping shows up in the first poll after a start, or in the first poll after the frame ends: the busy bit stays stuck, clears early, or a rejected command starts MDC running or overwrites the address fields.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
   localparam int CMD_WR_BIT = 27;
   localparam int CMD_RD_BIT = 26;
   localparam int REGAD_LSB  = 21;
   localparam int PHYAD_LSB  = 16;
   localparam int FIELD_W    = 5;
   localparam int DATA_W     = 16;

   localparam logic [1:0] OPC_READ  = 2'b10;
   localparam logic [1:0] OPC_WRITE = 2'b01;
   localparam logic [1:0] SOF_CODE  = 2'b01;

   typedef struct packed {
      logic                wr;
      logic                rd;
      logic [FIELD_W-1:0]  regad;
      logic [FIELD_W-1:0]  phyad;
   } mdio_cmd_t;
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
   parameter int DIV_HALF = 50
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic mdc,
   output logic rise_stb,
   output logic fall_stb
);
   logic tick;

   generate
      if (DIV_HALF < 1) begin : g_bad_div
         $error("DIV_HALF must be at least 1");
      end
      if (DIV_HALF == 1) begin : g_direct
         assign tick = en;
      end else begin : g_count
         localparam int CW = $clog2(DIV_HALF);
         logic [CW-1:0] cnt;
         assign tick = en && (cnt == CW'(DIV_HALF - 1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      cnt <= '0;
            else if (!en)    cnt <= '0;
            else if (tick)   cnt <= '0;
            else             cnt <= cnt + CW'(1);
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     mdc <= 1'b0;
      else if (!en)   mdc <= 1'b0;
      else if (tick)  mdc <= ~mdc;
   end

   assign rise_stb = tick && !mdc;
   assign fall_stb = tick && mdc;
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
   import mdio_mgmt_pkg::*;
#(
   parameter int PRE_LEN = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic               is_read,
   input  logic [FIELD_W-1:0] phyad,
   input  logic [FIELD_W-1:0] regad,
   input  logic [DATA_W-1:0]  wdata,
   input  logic               rise_stb,
   input  logic               fall_stb,
   input  logic               mdio_i,
   output logic               busy,
   output logic               done,
   output logic [DATA_W-1:0]  rdata,
   output logic               mdio_o,
   output logic               mdio_oe
);
   localparam int HDR_LEN    = 4 + 2 * FIELD_W;
   localparam int FRAME_LEN  = PRE_LEN + HDR_LEN + 2 + DATA_W;
   localparam int IW         = $clog2(FRAME_LEN);
   localparam int DRIVE_END  = PRE_LEN + HDR_LEN;
   localparam int DATA_START = DRIVE_END + 2;

   generate
      if (PRE_LEN < 1) begin : g_bad_pre
         $error("PRE_LEN must be at least 1");
      end
   endgenerate

   logic [FRAME_LEN-1:0] frame_w;
   logic [FRAME_LEN-1:0] shreg;
   logic [IW-1:0]        idx;
   logic                 rd_mode;
   logic                 last;

   assign frame_w = {{PRE_LEN{1'b1}}, SOF_CODE,
                     is_read ? OPC_READ : OPC_WRITE,
                     phyad, regad,
                     is_read ? 2'b11 : 2'b10,
                     is_read ? {DATA_W{1'b1}} : wdata};

   assign last = (idx == IW'(FRAME_LEN - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         done    <= 1'b0;
         idx     <= '0;
         shreg   <= '1;
         rd_mode <= 1'b0;
         rdata   <= '0;
      end else begin
         done <= 1'b0;
         if (start && !busy) begin
            busy    <= 1'b1;
            idx     <= '0;
            shreg   <= frame_w;
            rd_mode <= is_read;
         end else if (busy) begin
            if (rise_stb && rd_mode && (idx >= IW'(DATA_START)))
               rdata <= {rdata[DATA_W-2:0], mdio_i};
            if (fall_stb) begin
               if (last) begin
                  busy <= 1'b0;
                  done <= 1'b1;
               end else begin
                  idx   <= idx + IW'(1);
                  shreg <= {shreg[FRAME_LEN-2:0], 1'b1};
               end
            end
         end
      end
   end

   assign mdio_o  = shreg[FRAME_LEN-1];
   assign mdio_oe = busy && (!rd_mode || (idx < IW'(DRIVE_END)));
endmodule

// File: rtl/mdio_reg_bank.sv
module mdio_reg_bank
   import mdio_mgmt_pkg::*;
#(
   parameter int AW = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [AW-1:0]     bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              seq_done,
   input  logic [DATA_W-1:0] cap_data,
   output logic              start,
   output mdio_cmd_t         cmd,
   output logic [DATA_W-1:0] wdata
);
   localparam logic [AW-1:0] CTRL_ADDR  = AW'(0);
   localparam logic [AW-1:0] WDATA_ADDR = AW'(4);

   generate
      if (AW < 3) begin : g_bad_aw
         $error("AW must be at least 3");
      end
   endgenerate

   logic              ctrl_sel, wdat_sel, cmd_busy, both_cmd, accept;
   logic [DATA_W-1:0] rdval;
   logic [31:0]       ctrl_word;
   logic              unused_hi;

   assign ctrl_sel  = (bus_addr == CTRL_ADDR);
   assign wdat_sel  = (bus_addr == WDATA_ADDR);
   assign cmd_busy  = cmd.wr || cmd.rd;
   assign both_cmd  = bus_wdata[CMD_WR_BIT] && bus_wdata[CMD_RD_BIT];
   assign accept    = bus_wr && ctrl_sel && !cmd_busy && !both_cmd;
   assign unused_hi = ^bus_wdata[31:28];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd   <= '0;
         start <= 1'b0;
         rdval <= '0;
         wdata <= '0;
      end else begin
         start <= 1'b0;
         if (accept) begin
            cmd.wr    <= bus_wdata[CMD_WR_BIT];
            cmd.rd    <= bus_wdata[CMD_RD_BIT];
            cmd.regad <= bus_wdata[REGAD_LSB +: FIELD_W];
            cmd.phyad <= bus_wdata[PHYAD_LSB +: FIELD_W];
            start     <= bus_wdata[CMD_WR_BIT] || bus_wdata[CMD_RD_BIT];
         end else if (seq_done) begin
            if (cmd.rd) rdval <= cap_data;
            cmd.wr <= 1'b0;
            cmd.rd <= 1'b0;
         end
         if (bus_wr && wdat_sel)
            wdata <= bus_wdata[DATA_W-1:0];
      end
   end

   assign ctrl_word = {4'b0000, cmd.wr, cmd.rd, cmd.regad, cmd.phyad, rdval};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       bus_rdata <= '0;
      else if (bus_rd)  bus_rdata <= ctrl_sel ? ctrl_word :
                                     wdat_sel ? {16'h0000, wdata} : 32'h0;
   end
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
   import mdio_mgmt_pkg::*;
#(
   parameter int DIV_HALF = 50,
   parameter int PRE_LEN  = 32,
   parameter int AW       = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_wr,
   input  logic          bus_rd,
   input  logic [AW-1:0] bus_addr,
   input  logic [31:0]   bus_wdata,
   output logic [31:0]   bus_rdata,
   output logic          mdc,
   output logic          mdio_o,
   output logic          mdio_oe,
   input  logic          mdio_i
);
   mdio_cmd_t         cmd_q;
   logic              start, seq_busy, seq_done, rise_stb, fall_stb;
   logic [DATA_W-1:0] wdata_q, cap_data;

   mdio_reg_bank #(.AW(AW)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .seq_done(seq_done), .cap_data(cap_data), .start(start),
      .cmd(cmd_q), .wdata(wdata_q)
   );

   mdio_mdc_gen #(.DIV_HALF(DIV_HALF)) u_mdc (
      .clk(clk), .rst_n(rst_n), .en(seq_busy), .mdc(mdc),
      .rise_stb(rise_stb), .fall_stb(fall_stb)
   );

   mdio_frame_seq #(.PRE_LEN(PRE_LEN)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .is_read(cmd_q.rd),
      .phyad(cmd_q.phyad), .regad(cmd_q.regad), .wdata(wdata_q),
      .rise_stb(rise_stb), .fall_stb(fall_stb), .mdio_i(mdio_i),
      .busy(seq_busy), .done(seq_done), .rdata(cap_data),
      .mdio_o(mdio_o), .mdio_oe(mdio_oe)
   );
endmodule

// File: rtl/mdio_mgmt_checker.sv
module mdio_mgmt_checker (
   input logic        clk,
   input logic        rst_n,
   input logic        mdc,
   input logic        mdio_o,
   input logic        mdio_oe,
   input logic [31:0] bus_rdata,
   input logic        cmd_wr,
   input logic        cmd_rd,
   input logic [4:0]  phyad,
   input logic [4:0]  regad
);
   logic any_cmd;
   assign any_cmd = cmd_wr || cmd_rd;

   assert_one_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmd_wr && cmd_rd));

   assert_mdc_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !any_cmd |-> !mdc);

   assert_oe_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !any_cmd |-> !mdio_oe);

   assert_fields_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (any_cmd && $past(any_cmd)) |-> ($stable(phyad) && $stable(regad)));

   assert_no_change_on_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mdc) |-> $stable(mdio_o));

   assert_top_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rdata[31:28] == 4'b0000);
endmodule

bind mdio_mgmt_master mdio_mgmt_checker u_chk (
   .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
   .bus_rdata(bus_rdata), .cmd_wr(cmd_q.wr), .cmd_rd(cmd_q.rd),
   .phyad(cmd_q.phyad), .regad(cmd_q.regad)
);

// File: tb/mdio_mgmt_master_test.sv
module mdio_mgmt_master_test;
   localparam int DIVH = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        mdc, mdio_o, mdio_oe;
   logic        mdio_i = 1'b1;

   int errors = 0, checks = 0, cyc = 0, rises = 0;
   int rise_t [0:1];
   logic [63:0] seen_o, seen_oe;
   logic [15:0] phy_val = '0;
   logic [15:0] last_rd = '0;
   bit finished = 0;

   always #2 clk = ~clk;
   always @(posedge clk) cyc++;

   mdio_mgmt_master #(.DIV_HALF(DIVH), .PRE_LEN(32), .AW(3)) uut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
   );

   // PHY model: records each bit at MDC rise, presents next read bit after it
   always @(posedge mdc) begin
      if (rises < 64) begin
         seen_o[63-rises]  = mdio_o;
         seen_oe[63-rises] = mdio_oe;
      end
      if (rises < 2) rise_t[rises] = cyc;
      rises++;
      #1;
      if (rises >= 48 && rises < 64) mdio_i = phy_val[63-rises];
      else mdio_i = 1'b1;
   end

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic bus_write(logic [2:0] a, logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   function automatic logic [31:0] mk_ctrl(logic w, logic r, logic [4:0] ra,
                                           logic [4:0] pa, logic [15:0] lo);
      return {4'b0000, w, r, ra, pa, lo};
   endfunction

   task automatic wait_idle();
      logic [31:0] v;
      int n = 0;
      do begin
         bus_read(3'd0, v);
         n++;
      end while (v[27:26] != 2'b00 && n < 1000);
   endtask

   task automatic run_frame(bit rd, logic [4:0] pa, logic [4:0] ra,
                            logic [15:0] wd, logic [15:0] pv);
      logic [31:0] v;
      logic [63:0] exp_o, exp_oe, mask;
      phy_val = pv;
      if (!rd) bus_write(3'd4, {16'h0, wd});
      rises = 0;
      bus_write(3'd0, mk_ctrl(!rd, rd, ra, pa, 16'h0));
      bus_read(3'd0, v);
      chk(rd ? "R4 read busy" : "R4 write busy", 64'(v[27:26]),
          rd ? 64'd1 : 64'd2);
      wait_idle();
      bus_read(3'd0, v);
      if (rd) last_rd = pv;
      chk("R4 command cleared and R3 data", 64'(v), 64'(mk_ctrl(0, 0, ra, pa, last_rd)));
      chk("R2/R3 edge count", 64'(rises), 64'd64);
      exp_o  = {32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, pa, ra, 2'b10, wd};
      mask   = rd ? {{46{1'b1}}, 18'h0} : '1;
      exp_oe = rd ? {{46{1'b1}}, 18'h0} : '1;
      chk(rd ? "R3 read frame bits" : "R2 write frame bits",
          seen_o & mask, exp_o & mask);
      chk(rd ? "R3 output enable" : "R2 output enable", seen_oe, exp_oe);
      chk("R8 MDC period", 64'(rise_t[1] - rise_t[0]), 64'(2 * DIVH));
      chk("R8 MDC idle low", 64'(mdc), 64'd0);
   endtask

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      bus_read(3'd0, v); chk("R1 ctrl reset", 64'(v), 64'd0);
      bus_read(3'd4, v); chk("R1 wdata reset", 64'(v), 64'd0);
      chk("R1 mdc/oe reset", 64'({mdc, mdio_oe}), 64'd0);

      // R9: only low half of write-data word kept; unknown address reads zero
      bus_write(3'd4, 32'hFFFF_ABCD);
      bus_read(3'd4, v); chk("R9 wdata width", 64'(v), 64'h0000ABCD);
      bus_read(3'd2, v); chk("R9 unmapped read", 64'(v), 64'd0);

      // sweep of all PHY addresses, write then read
      for (int p = 0; p < 32; p++) begin
         logic [4:0]  ra = 5'((p * 11 + 3) % 32);
         logic [15:0] wd = 16'((p * 2731) ^ 16'h5A3C);
         logic [15:0] pv = 16'((p * 40503 + 777) ^ 16'hC3A5);
         run_frame(1'b0, 5'(p), ra, wd, pv);
         run_frame(1'b1, 5'(p), 5'(31 - p), wd, pv);
      end

      // R7: command write without command bits updates addresses only
      bus_write(3'd0, 32'hF000_FFFF | mk_ctrl(0, 0, 5'd6, 5'd5, 16'h0));
      bus_read(3'd0, v);
      chk("R7 field update and zero top", 64'(v), 64'(mk_ctrl(0, 0, 5'd6, 5'd5, last_rd)));

      // R6: both command bits set is ignored
      rises = 0;
      bus_write(3'd0, mk_ctrl(1, 1, 5'd9, 5'd7, 16'h0));
      repeat (40) @(negedge clk);
      bus_read(3'd0, v);
      chk("R6 both bits ignored", 64'(v), 64'(mk_ctrl(0, 0, 5'd6, 5'd5, last_rd)));
      chk("R6 no frame", 64'(rises), 64'd0);

      // R5: command write during a running frame is ignored
      rises = 0;
      bus_write(3'd4, 32'h0000_1234);
      bus_write(3'd0, mk_ctrl(1, 0, 5'd4, 5'd3, 16'h0));
      repeat (20) @(negedge clk);
      bus_write(3'd0, mk_ctrl(0, 1, 5'd10, 5'd9, 16'h0));
      bus_read(3'd0, v);
      chk("R5 fields held while busy", 64'(v), 64'(mk_ctrl(1, 0, 5'd4, 5'd3, last_rd)));
      wait_idle();
      repeat (300) @(negedge clk);
      chk("R5 no second frame", 64'(rises), 64'd64);
      bus_read(3'd0, v);
      chk("R5 final ctrl", 64'(v), 64'(mk_ctrl(0, 0, 5'd4, 5'd3, last_rd)));

      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         errors++; checks++;
         $display("FAIL watchdog: run did not complete");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule